// File: doc/BRIEF.md
# I2C Master Host Register Front End

This block is the software-facing side of an I2C master that works through FIFOs. A simple 32-bit register bus sits on one side. A bit-level bus engine sits on the other. Software queues the target address and the payload in a 9-bit transmit queue. The command flag in bit 8 tells the engine which entries open a transfer with an address. Bytes the engine receives collect in an 8-bit receive queue. Both queues are reached through one data offset: a write pushes to the transmit queue, and a read pops from the receive queue.

Four engine conditions are latched into a sticky interrupt status: transmit queue drained, requested byte count received, missing acknowledge, and arbitration lost. An enable mask and a write-one-to-clear register act on this status, and a single interrupt line results. The block also passes on the following to the engine:

- start and stop strobes;
- master and NACK levels;
- the slave address;
- four bus timing values and two byte counts;
- the run and SCL-release controls;
- a forced bus reset request.

Read data returns on `rsp_rdata` one clock after the read request. All registers are word-aligned and decoded on `req_addr`.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset, every register reads 0, except the status word, which reads 0x0000_0003 (transmit queue empty and not full). `irq` is 0 and `eng_tx_valid` is 0.
- R2: A write to offset 0x04 pushes `req_wdata[8:0]` into the transmit queue, where bit 8 is the command flag. The engine sees the entries on `eng_tx_data` in push order, while `eng_tx_valid` is high.
- R3: The transmit queue holds 8 entries. A push while it is full is discarded, and status bit 1 (transmit not full) reads 0 while it is full.
- R4: A read of offset 0x04 pops the receive queue in arrival order. A read of an empty receive queue returns 0 and leaves the queue unchanged.
- R5: The status word at 0x2C has these bits: bit 12 engine device busy, bit 8 bus busy, bit 3 receive queue full (8 entries), bit 2 receive queue not empty, bit 1 transmit not full, bit 0 transmit empty.
- R6: The interrupt bits are bit 9 drained, bit 4 receive done, bit 2 no acknowledge and bit 1 arbitration lost. An event pulse sets its bit in the status at 0x20. The bit stays set until a 1 is written to the same position at 0x28, and writing 0 at 0x28 leaves a bit alone.
- R7: An event that arrives in the same cycle as a clear of its bit leaves the bit set.
- R8: `irq` is high exactly when some bit is set both in the interrupt status and in the enable register at 0x24.
- R9: In the reset register at 0x34, writing bit 2 empties the transmit queue and writing bit 1 empties the receive queue. Each of these bits reads 1 in the read issued the cycle after the write, and 0 after that. Bit 0 drives `bus_reset_req` and reads 1 until `bus_reset_done` pulses.
- R10: In the control register at 0x00, bit 3 (master) and bit 0 (NACK) are held levels that read back. Writing bit 2 or bit 1 gives a single-cycle pulse on `ctl_start` or `ctl_stop` in the cycle after the write, and these two bits read as 0.
- R11: The following registers read back and drive their outputs: slave address 0x0C bits [6:0], the 16-bit timing registers 0x10/0x14/0x18/0x1C, the byte counts 0x40/0x44, and the bus-reset control 0x50 (bit 1 run, bit 0 SCL release). Offsets 0x48/0x4C return the engine's count monitors.
- R12: When the engine pops the last entry of the transmit queue, interrupt status bit 9 is set on the next cycle.
- R13: Offsets 0x08 and 0x30 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid one cycle after the read request |
| irq | output | 1 | Interrupt line |
| eng_tx_valid | output | 1 | Transmit queue holds an entry |
| eng_tx_data | output | 9 | Head of the transmit queue, bit 8 = command |
| eng_tx_pop | input | 1 | Engine consumes the head entry |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| evt_rx_done | input | 1 | Pulse: requested byte count received |
| evt_no_ack | input | 1 | Pulse: target gave no acknowledge |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| eng_dev_busy | input | 1 | Engine is in a transfer |
| eng_bus_busy | input | 1 | Bus is occupied |
| eng_tx_cnt_mon | input | 16 | Bytes sent so far |
| eng_rx_cnt_mon | input | 16 | Bytes received so far |
| bus_reset_done | input | 1 | Pulse: forced bus reset has finished |
| ctl_master | output | 1 | Master mode level |
| ctl_start | output | 1 | Start strobe |
| ctl_stop | output | 1 | Stop strobe |
| ctl_nack | output | 1 | NACK the next received byte |
| slave_addr | output | 7 | Slave address setting |
| tim_cycle | output | 16 | SCL cycle length |
| tim_low | output | 16 | SCL low period |
| tim_rs_setup | output | 16 | Restart/stop setup time |
| tim_dat_setup | output | 16 | Data setup time |
| tx_byte_cnt | output | 16 | Transmit byte count setting |
| rx_byte_cnt | output | 16 | Receive byte count setting |
| run_enable | output | 1 | Normal operation enable |
| scl_release | output | 1 | Release SCL from low hold |
| bus_reset_req | output | 1 | Forced bus reset request |

## Verification
The assertions assume that the engine pulses `eng_tx_pop` only while `eng_tx_valid` is high, or that an extra pop is harmless. They also assume the event inputs are single-cycle pulses. The queue-overflow and underflow assertions do not depend on the request stream. The random phase keeps every event and pop to a single cycle. It sends receive bytes only while the modelled receive queue has room. It attempts transmit pops and receive reads on empty queues on purpose, to exercise the discard paths.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CTL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_SADR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CYC   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_LOW   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_RSSU  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_DSU   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_ICLR  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_RST   = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_BMON  = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_NOISE = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_TXBC  = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_RXBC  = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_TXBM  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_RXBM  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_BRST  = 8'h50;

  // compact interrupt vector order: [3] drained, [2] rx done, [1] no ack, [0] arb lost
  localparam int NIRQ = 4;

  typedef struct packed {
    logic dev_busy;
    logic bus_busy;
    logic rx_full;
    logic rx_nonempty;
    logic tx_notfull;
    logic tx_empty;
  } stat_t;

  function automatic logic [31:0] irq_spread(input logic [NIRQ-1:0] c);
    logic [31:0] w;
    w    = '0;
    w[9] = c[3];
    w[4] = c[2];
    w[2] = c[1];
    w[1] = c[0];
    return w;
  endfunction

  function automatic logic [NIRQ-1:0] irq_gather(input logic [31:0] w);
    return {w[9], w[4], w[2], w[1]};
  endfunction

  function automatic logic [31:0] status_word(input stat_t s);
    logic [31:0] w;
    w     = '0;
    w[12] = s.dev_busy;
    w[8]  = s.bus_busy;
    w[3]  = s.rx_full;
    w[2]  = s.rx_nonempty;
    w[1]  = s.tx_notfull;
    w[0]  = s.tx_empty;
    return w;
  endfunction

endpackage

// File: rtl/i2c_host_fifo.sv
module i2c_host_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH):0] count
);
  // DEPTH is a power of two so the pointers wrap on their own
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  // R3: a push into a full queue leaves the fill level alone
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));
  // R4: a pop from an empty queue leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/i2c_host_irq.sv
module i2c_host_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_eff) | ev;   // new event beats the clear
      if (en_we) en <= en_wdata;
    end
  end

  assign irq = |(stat & en);

  // R7: every event bit shows up in the status next cycle, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((stat & $past(ev)) == $past(ev)));
  // R6: without a clear write, latched bits do not drop
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TIM_W      = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              irq,
  output logic              eng_tx_valid,
  output logic [8:0]        eng_tx_data,
  input  logic              eng_tx_pop,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  input  logic              evt_rx_done,
  input  logic              evt_no_ack,
  input  logic              evt_arb_lost,
  input  logic              eng_dev_busy,
  input  logic              eng_bus_busy,
  input  logic [CNT_W-1:0]  eng_tx_cnt_mon,
  input  logic [CNT_W-1:0]  eng_rx_cnt_mon,
  input  logic              bus_reset_done,
  output logic              ctl_master,
  output logic              ctl_start,
  output logic              ctl_stop,
  output logic              ctl_nack,
  output logic [6:0]        slave_addr,
  output logic [TIM_W-1:0]  tim_cycle,
  output logic [TIM_W-1:0]  tim_low,
  output logic [TIM_W-1:0]  tim_rs_setup,
  output logic [TIM_W-1:0]  tim_dat_setup,
  output logic [CNT_W-1:0]  tx_byte_cnt,
  output logic [CNT_W-1:0]  rx_byte_cnt,
  output logic              run_enable,
  output logic              scl_release,
  output logic              bus_reset_req
);
  localparam int TX_W  = 9;
  localparam int RX_W  = 8;
  localparam int FCW   = $clog2(FIFO_DEPTH) + 1;
  localparam int NOISE_W = 4;

  // decoded bus strobes
  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  logic wr_ctl, wr_data, wr_ien, wr_iclr, wr_rst, rd_data;
  assign wr_ctl  = wr && (req_addr == OFF_CTL);
  assign wr_data = wr && (req_addr == OFF_DATA);
  assign wr_ien  = wr && (req_addr == OFF_IEN);
  assign wr_iclr = wr && (req_addr == OFF_ICLR);
  assign wr_rst  = wr && (req_addr == OFF_RST);
  assign rd_data = rd && (req_addr == OFF_DATA);

  // reset register state
  logic tx_flush_q, rx_flush_q, bus_rst_q;

  // transmit queue
  logic            tx_empty, tx_full, tx_pop_eff, tx_drained;
  logic [FCW-1:0]  tx_count;
  i2c_host_fifo #(.W(TX_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush_q),
    .push(wr_data), .wdata(req_wdata[TX_W-1:0]),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .empty(tx_empty), .full(tx_full), .count(tx_count));

  assign eng_tx_valid = !tx_empty;
  assign tx_pop_eff   = eng_tx_pop && !tx_empty && !tx_flush_q;
  // engine takes the last entry and nothing refills it this cycle
  assign tx_drained   = tx_pop_eff && (tx_count == FCW'(1)) && !wr_data;

  // receive queue
  logic            rx_empty, rx_full;
  logic [RX_W-1:0] rx_head;
  logic [FCW-1:0]  rx_count;
  i2c_host_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush_q),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rd_data), .rdata(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count));

  // interrupt status
  logic [NIRQ-1:0] ev_vec, istat, ien;
  assign ev_vec = {tx_drained, evt_rx_done, evt_no_ack, evt_arb_lost};
  i2c_host_irq #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec),
    .en_we(wr_ien), .en_wdata(irq_gather(req_wdata)),
    .clr_we(wr_iclr), .clr_mask(irq_gather(req_wdata)),
    .stat(istat), .en(ien), .irq(irq));

  // configuration registers
  logic [NOISE_W-1:0] noise_q;
  logic [1:0]         brst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_master    <= 1'b0;
      ctl_nack      <= 1'b0;
      ctl_start     <= 1'b0;
      ctl_stop      <= 1'b0;
      slave_addr    <= '0;
      tim_cycle     <= '0;
      tim_low       <= '0;
      tim_rs_setup  <= '0;
      tim_dat_setup <= '0;
      tx_byte_cnt   <= '0;
      rx_byte_cnt   <= '0;
      noise_q       <= '0;
      brst_q        <= '0;
    end else begin
      ctl_start <= wr_ctl && req_wdata[2];
      ctl_stop  <= wr_ctl && req_wdata[1];
      if (wr_ctl) begin
        ctl_master <= req_wdata[3];
        ctl_nack   <= req_wdata[0];
      end
      if (wr) begin
        case (req_addr)
          OFF_SADR:  slave_addr    <= req_wdata[6:0];
          OFF_CYC:   tim_cycle     <= req_wdata[TIM_W-1:0];
          OFF_LOW:   tim_low       <= req_wdata[TIM_W-1:0];
          OFF_RSSU:  tim_rs_setup  <= req_wdata[TIM_W-1:0];
          OFF_DSU:   tim_dat_setup <= req_wdata[TIM_W-1:0];
          OFF_TXBC:  tx_byte_cnt   <= req_wdata[CNT_W-1:0];
          OFF_RXBC:  rx_byte_cnt   <= req_wdata[CNT_W-1:0];
          OFF_NOISE: noise_q       <= req_wdata[NOISE_W-1:0];
          OFF_BRST:  brst_q        <= req_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign run_enable  = brst_q[1];
  assign scl_release = brst_q[0];

  // self-clearing reset actions: flushes finish one cycle after the write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
      bus_rst_q  <= 1'b0;
    end else begin
      tx_flush_q <= wr_rst && req_wdata[2];
      rx_flush_q <= wr_rst && req_wdata[1];
      if (wr_rst && req_wdata[0])  bus_rst_q <= 1'b1;
      else if (bus_reset_done)     bus_rst_q <= 1'b0;
    end
  end
  assign bus_reset_req = bus_rst_q;

  // read mux
  stat_t       st;
  logic [31:0] rd_word;

  always_comb begin
    st.dev_busy    = eng_dev_busy;
    st.bus_busy    = eng_bus_busy;
    st.rx_full     = rx_full;
    st.rx_nonempty = !rx_empty;
    st.tx_notfull  = !tx_full;
    st.tx_empty    = tx_empty;
  end

  always_comb begin
    rd_word = '0;
    case (req_addr)
      OFF_CTL:   rd_word = {28'd0, ctl_master, 2'b00, ctl_nack};
      OFF_DATA:  rd_word = {24'd0, rx_head};
      OFF_SADR:  rd_word = {25'd0, slave_addr};
      OFF_CYC:   rd_word = 32'(tim_cycle);
      OFF_LOW:   rd_word = 32'(tim_low);
      OFF_RSSU:  rd_word = 32'(tim_rs_setup);
      OFF_DSU:   rd_word = 32'(tim_dat_setup);
      OFF_ISTAT: rd_word = irq_spread(istat);
      OFF_IEN:   rd_word = irq_spread(ien);
      OFF_STAT:  rd_word = status_word(st);
      OFF_RST:   rd_word = {29'd0, tx_flush_q, rx_flush_q, bus_rst_q};
      OFF_BMON:  rd_word = '0;
      OFF_NOISE: rd_word = 32'(noise_q);
      OFF_TXBC:  rd_word = 32'(tx_byte_cnt);
      OFF_RXBC:  rd_word = 32'(rx_byte_cnt);
      OFF_TXBM:  rd_word = 32'(eng_tx_cnt_mon);
      OFF_RXBM:  rd_word = 32'(eng_rx_cnt_mon);
      OFF_BRST:  rd_word = {30'd0, brst_q};
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rsp_rdata <= '0;
    else if (rd) rsp_rdata <= rd_word;
  end

  // R12: draining the queue latches the drained interrupt bit
  a_r12_drain_latched: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drained |=> istat[3]);
  // R9: a flush request lasts one cycle unless rewritten
  a_r9_flush_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_q && !(wr_rst && req_wdata[2])) |=> !tx_flush_q);
  // R9: a flush leaves the transmit queue empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_q |=> tx_empty);
  // R10: a start strobe never lasts two cycles without a second write
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start && !(wr_ctl && req_wdata[2])) |=> !ctl_start);
endmodule

// File: tb/test_i2c_host_regs.sv
module test_i2c_host_regs;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata;
  logic        irq, eng_tx_valid;
  logic [8:0]  eng_tx_data;
  logic        eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  eng_rx_data = 0;
  logic        evt_rx_done = 0, evt_no_ack = 0, evt_arb_lost = 0;
  logic        eng_dev_busy = 0, eng_bus_busy = 0;
  logic [15:0] eng_tx_cnt_mon = 16'h0011, eng_rx_cnt_mon = 16'h0022;
  logic        bus_reset_done = 0;
  logic        ctl_master, ctl_start, ctl_stop, ctl_nack;
  logic [6:0]  slave_addr;
  logic [15:0] tim_cycle, tim_low, tim_rs_setup, tim_dat_setup, tx_byte_cnt, rx_byte_cnt;
  logic        run_enable, scl_release, bus_reset_req;

  i2c_host_regs i_i2c_host_regs (.*);

  int nrun = 0, nfail = 0;
  bit done = 0;

  // bench queue models
  int tq[8]; int th = 0, tc = 0;
  int rq[8]; int rh = 0, rc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic bwr(logic [7:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    step();
    req_valid = 0; req_write = 0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    step();
    d = rsp_rdata;
    req_valid = 0;
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] w = 0;
    w[12] = eng_dev_busy; w[8] = eng_bus_busy;
    w[3] = (rc == 8); w[2] = (rc != 0); w[1] = (tc != 8); w[0] = (tc == 0);
    return w;
  endfunction

  task automatic tx_push(int v);
    bwr(8'h04, 32'(v));
    if (tc < 8) begin tq[(th + tc) % 8] = v & 9'h1FF; tc++; end
  endtask

  task automatic tx_pop(string tag);
    chk(tag, {31'd0, eng_tx_valid}, {31'd0, tc != 0});
    if (tc != 0) chk(tag, 32'(eng_tx_data), 32'(tq[th]));
    eng_tx_pop = 1; step(); eng_tx_pop = 0;
    if (tc != 0) begin th = (th + 1) % 8; tc--; end
  endtask

  task automatic rx_push(int v);
    eng_rx_push = 1; eng_rx_data = 8'(v); step(); eng_rx_push = 0;
    if (rc < 8) begin rq[(rh + rc) % 8] = v & 8'hFF; rc++; end
  endtask

  task automatic rx_read(string tag);
    logic [31:0] d;
    int e;
    e = (rc != 0) ? rq[rh] : 0;
    brd(8'h04, d);
    chk(tag, d, 32'(e));
    if (rc != 0) begin rh = (rh + 1) % 8; rc--; end
  endtask

  initial begin
    #500000;
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    step(); step(); rst_n = 1; step();

    // R1 reset state
    brd(8'h2C, d); chk("R1 status", d, 32'h3);
    brd(8'h20, d); chk("R1 istat", d, 0);
    brd(8'h00, d); chk("R1 ctl", d, 0);
    brd(8'h10, d); chk("R1 cycle", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 txvalid", {31'd0, eng_tx_valid}, 0);

    // R13 holes
    bwr(8'h08, 32'hFFFF_FFFF); bwr(8'h30, 32'hFFFF_FFFF);
    brd(8'h08, d); chk("R13 0x08", d, 0);
    brd(8'h30, d); chk("R13 0x30", d, 0);
    brd(8'h2C, d); chk("R13 status untouched", d, 32'h3);
    brd(8'h00, d); chk("R13 ctl untouched", d, 0);

    // R11 config registers
    bwr(8'h10, 32'hABCD_1234); bwr(8'h14, 32'h0000_0050); bwr(8'h18, 32'h61);
    bwr(8'h1C, 32'h0C); bwr(8'h0C, 32'hFF); bwr(8'h40, 32'h0003); bwr(8'h44, 32'h0004);
    bwr(8'h50, 32'h3);
    brd(8'h10, d); chk("R11 cycle rb", d, 32'h1234);
    chk("R11 cycle out", 32'(tim_cycle), 32'h1234);
    chk("R11 low out", 32'(tim_low), 32'h50);
    chk("R11 setup outs", {tim_rs_setup, tim_dat_setup}, {16'h61, 16'h0C});
    brd(8'h0C, d); chk("R11 sadr", d, 32'h7F);
    chk("R11 counts", {tx_byte_cnt, rx_byte_cnt}, {16'd3, 16'd4});
    chk("R11 brst outs", {30'd0, run_enable, scl_release}, 32'h3);
    brd(8'h48, d); chk("R11 txmon", d, 32'h11);
    brd(8'h4C, d); chk("R11 rxmon", d, 32'h22);

    // R10 control
    req_valid = 1; req_write = 1; req_addr = 8'h00; req_wdata = 32'hC;
    step(); req_valid = 0;
    chk("R10 start pulse", {29'd0, ctl_start, ctl_stop, ctl_master}, 32'b101);
    step();
    chk("R10 pulse ends", {31'd0, ctl_start}, 0);
    bwr(8'h00, 32'hB);
    chk("R10 stop nack", {29'd0, ctl_stop, ctl_nack, ctl_start}, 32'b110);
    brd(8'h00, d); chk("R10 ctl rb", d, 32'h9);

    // R2 / R3 order and overflow
    for (int i = 0; i < 9; i++) tx_push((i == 0 ? 32'h100 : 0) | (i * 17 + 3));
    brd(8'h2C, d); chk("R3 full status", d, exp_stat());
    chk("R3 notfull bit", {31'd0, d[1]}, 0);
    for (int i = 0; i < 8; i++) tx_pop("R2 order");
    chk("R3 ninth dropped", {31'd0, eng_tx_valid}, 0);

    // R12 drained event (set by the last pop above)
    brd(8'h20, d); chk("R12 drained bit", d, 32'h200);
    bwr(8'h28, 32'h200);
    tx_push(32'h5A); tx_pop("R2 single"); step();
    brd(8'h20, d); chk("R12 drained again", d, 32'h200);
    bwr(8'h28, 32'hFFFF_FFFF);

    // R6 / R8 / R7
    evt_no_ack = 1; step(); evt_no_ack = 0;
    brd(8'h20, d); chk("R6 no ack latched", d, 32'h4);
    chk("R8 masked", {31'd0, irq}, 0);
    bwr(8'h24, 32'h4);
    chk("R8 enabled", {31'd0, irq}, 1);
    bwr(8'h28, 32'h2);
    brd(8'h20, d); chk("R6 zero clear bit keeps", d, 32'h4);
    bwr(8'h28, 32'h4);
    brd(8'h20, d); chk("R6 cleared", d, 0);
    chk("R8 drops", {31'd0, irq}, 0);
    evt_arb_lost = 1; bwr(8'h28, 32'h2); evt_arb_lost = 0;
    brd(8'h20, d); chk("R7 event beats clear", d, 32'h2);
    evt_rx_done = 1; step(); evt_rx_done = 0;
    brd(8'h20, d); chk("R6 rx done", d, 32'h12);
    chk("R8 other bit masked", {31'd0, irq}, 0);
    bwr(8'h24, 32'h10); chk("R8 rx done enabled", {31'd0, irq}, 1);
    bwr(8'h28, 32'h16); bwr(8'h24, 0);

    // R4 / R5 receive side
    rx_read("R4 empty read");
    for (int i = 0; i < 8; i++) rx_push(8'hA0 + i);
    eng_dev_busy = 1; eng_bus_busy = 1;
    brd(8'h2C, d); chk("R5 full busy status", d, exp_stat());
    eng_dev_busy = 0; eng_bus_busy = 0;
    for (int i = 0; i < 3; i++) rx_read("R4 order");

    // R9 flushes and bus reset
    tx_push(1); tx_push(2);
    bwr(8'h34, 32'h6);
    brd(8'h34, d); chk("R9 flush bits read 1", d, 32'h6);
    th = 0; tc = 0; rh = 0; rc = 0;
    brd(8'h34, d); chk("R9 flush bits cleared", d, 0);
    brd(8'h2C, d); chk("R9 queues empty", d, 32'h3);
    bwr(8'h34, 32'h1);
    step(); step();
    brd(8'h34, d); chk("R9 bus reset held", d, 32'h1);
    chk("R9 bus reset out", {31'd0, bus_reset_req}, 1);
    bus_reset_done = 1; step(); bus_reset_done = 0;
    brd(8'h34, d); chk("R9 bus reset done", d, 0);

    // random mix against the models
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: tx_push($urandom & 32'h1FF);
        1: tx_pop("R2 random pop");
        2: if (rc < 8) rx_push($urandom);
        3: rx_read("R4 random read");
        default: begin
          eng_dev_busy = 1'($urandom); eng_bus_busy = 1'($urandom);
        end
      endcase
      brd(8'h2C, d); chk("R5 random status", d, exp_stat());
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule